// File: doc/BRIEF.md
# Bounded Wrap-Around Up Counter

This block is a synchronous up counter of parameterised width that runs through a fixed window of values, from a start value `LO` up to an end value `HI`, and then starts again at `LO`. The counter is built from a loadable binary counter core and a small compare unit. The compare unit watches for the end value while counting is enabled. When it sees the end value, it forces a parallel load of the start value on the next edge. The core does not go back to zero.

With `LO = 0` the block is a plain modulo-(`HI`+1) counter. A synchronous clear sends the count to zero at any time. If zero is below `LO`, the counter climbs from zero into the window and then wraps in the normal way. When the enable input is low, the count stays where it is. A terminal-count flag reports when the core is at its all-ones value and is enabled, so that a further stage can be chained after this one.

Top module: `range_counter`

## Requirements
- R1: When `clr` is 1 at a rising edge, `count` is 0 after that edge. This holds whatever the values of `cnt_en` and `count`.
- R2: When `clr` is 0, `cnt_en` is 1 and `count` is not `HI`, `count` becomes (`count`+1) modulo 2^`W` at the edge.
- R3: When `clr` is 0, `cnt_en` is 1 and `count` equals `HI`, `count` becomes `LO` at the edge, even when `HI` is 2^`W`-1.
- R4: When `clr` is 0 and `cnt_en` is 0, `count` keeps its value at the edge, and this includes the case where `count` equals `HI`.
- R5: `term_cnt` is 1 exactly when `count` equals 2^`W`-1 and `cnt_en` is 1. It is 0 at all other times. The flag is combinational from the registered count and the enable.
- R6: After a clear, when `LO` > 0, the counter steps 0, 1, …, `LO`-1 and enters the window. From then on it never goes above `HI`.
- R7: With enable held high after a clear, the counter runs through the full cycle `LO`…`HI` and repeats it. For `LO`=0, `HI`=5 the period is 6. For `LO`=5, `HI`=11 the period is 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous active-high clear to zero |
| cnt_en | input | 1 | Count enable |
| count | output | W | Registered count value |
| term_cnt | output | 1 | High when count is all ones and enable is high |

## Verification
The assertions take as given that the bounds meet 0 ≤ `LO` < `HI` ≤ 2^`W`-1. Elaboration stops if they do not. The assertions also take as given that `clr` is high before the first edge, so the count starts from a known value. The stimulus holds `clr` high from time zero. It only drives three legal windows: (0,5), (5,11) and (3,15). Within those windows it mixes long enabled runs, enable gaps that land on the end value, and clears issued at the end value while enabled.

// File: rtl/rc_pkg.sv
package rc_pkg;
  // Next-state operation chosen for the counter register, in priority order.
  typedef enum logic [1:0] {
    RC_HOLD  = 2'd0,
    RC_INC   = 2'd1,
    RC_LOAD  = 2'd2,
    RC_CLEAR = 2'd3
  } rc_op_e;
endpackage

// File: rtl/rc_op_select.sv
module rc_op_select
  import rc_pkg::*;
(
  input  logic   clr,
  input  logic   ld,
  input  logic   cnt,
  output rc_op_e op
);
  // Clear beats load, load beats increment, and increment beats hold.
  always_comb begin
    if (clr)      op = RC_CLEAR;
    else if (ld)  op = RC_LOAD;
    else if (cnt) op = RC_INC;
    else          op = RC_HOLD;
  end
endmodule

// File: rtl/rc_core.sv
module rc_core
  import rc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic         cnt,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  rc_op_e op;

  rc_op_select u_sel (
    .clr (clr),
    .ld  (ld),
    .cnt (cnt),
    .op  (op)
  );

  always_ff @(posedge clk) begin
    case (op)
      RC_CLEAR: q <= '0;
      RC_LOAD:  q <= d;
      RC_INC:   q <= q + 1'b1;
      default:  q <= q;
    endcase
  end

  assign tc = cnt && (q == ALL_ONES);

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> (q == '0)) else $error("clear did not zero"); // R1
  AST_INCREMENT: assert property (@(posedge clk) disable iff (clr)
    ($past(cnt) && !$past(ld) && !$past(clr)) |-> (q == W'($past(q) + 1'b1)))
    else $error("bad increment"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
    (!$past(cnt) && !$past(ld) && !$past(clr)) |-> $stable(q))
    else $error("count moved while idle"); // R4
endmodule

// File: rtl/rc_wrap_decode.sv
module rc_wrap_decode #(
  parameter int W  = 4,
  parameter int LO = 5,
  parameter int HI = 11
) (
  input  logic         cnt,
  input  logic [W-1:0] q,
  output logic         ld,
  output logic [W-1:0] d
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  // A load happens only when counting is enabled and the end value is present.
  assign ld = cnt && (q == HI_V);
  assign d  = LO_V;
endmodule

// File: rtl/range_counter.sv
module range_counter #(
  parameter int W  = 4,
  parameter int LO = 5,
  parameter int HI = 11
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         cnt_en,
  output logic [W-1:0] count,
  output logic         term_cnt
);
  localparam int MAXV = (1 << W) - 1;
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  generate
    if (!(LO >= 0 && LO < HI && HI <= MAXV)) begin : g_bad_bounds
      $error("range_counter: bounds must satisfy 0 <= LO < HI <= 2**W-1");
    end
  endgenerate

  logic         ld;
  logic [W-1:0] d;

  rc_wrap_decode #(.W(W), .LO(LO), .HI(HI)) u_dec (
    .cnt (cnt_en),
    .q   (count),
    .ld  (ld),
    .d   (d)
  );

  rc_core #(.W(W)) u_core (
    .clk (clk),
    .clr (clr),
    .ld  (ld),
    .cnt (cnt_en),
    .d   (d),
    .q   (count),
    .tc  (term_cnt)
  );

  AST_WRAP_TO_LO: assert property (@(posedge clk) disable iff (clr)
    (cnt_en && count == HI_V) |=> (count == LO_V)) else $error("no wrap"); // R3
  AST_NEVER_ABOVE_HI: assert property (@(posedge clk) disable iff (clr)
    $past(clr) || (count <= HI_V) || ($past(count) <= HI_V && count <= HI_V))
    else $error("count above end"); // R6
  AST_HOLD_AT_END: assert property (@(posedge clk) disable iff (clr)
    (!cnt_en && count == HI_V) |=> (count == HI_V)) else $error("moved at end"); // R4
  AST_TC_AT_MAX: assert property (@(posedge clk) disable iff (clr)
    term_cnt |-> (count == W'(MAXV) && cnt_en)) else $error("stray tc"); // R5
endmodule

// File: tb/range_counter_tb.sv
module range_counter_tb;
  localparam int W = 4;
  localparam int N = 3;
  localparam int LOS [N] = '{0, 5, 3};
  localparam int HIS [N] = '{5, 11, 15};

  typedef struct {
    int         idx;
    logic [3:0] exp_q;
    logic       exp_tc;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic en  = 1'b0;
  logic [W-1:0] cnt_w [N];
  logic         tc_w  [N];

  always #4 clk = ~clk; // 125 MHz

  for (genvar g = 0; g < N; g++) begin : gen_dut
    range_counter #(.W(W), .LO(LOS[g]), .HI(HIS[g])) u_dut (
      .clk      (clk),
      .clr      (clr),
      .cnt_en   (en),
      .count    (cnt_w[g]),
      .term_cnt (tc_w[g])
    );
  end

  int checks = 0;
  int fails  = 0;
  item_t sb[$];
  logic [3:0] model [N];

  task automatic step(input logic c, input logic e);
    item_t it;
    string tg [N];
    @(negedge clk);
    clr = c;
    en  = e;
    for (int i = 0; i < N; i++) begin
      if (c)                        begin model[i] = 0; tg[i] = "R1"; end
      else if (!e)                  tg[i] = "R4";
      else if (model[i] == HIS[i])  begin model[i] = 4'(LOS[i]); tg[i] = "R3"; end
      else if (model[i] < LOS[i])   begin model[i] = model[i] + 1; tg[i] = "R6"; end
      else                          begin model[i] = model[i] + 1; tg[i] = "R2"; end
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      it.idx = i; it.exp_q = model[i];
      it.exp_tc = e && (model[i] == 4'hF);
      it.tag = tg[i];
      sb.push_back(it);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (cnt_w[it.idx] !== it.exp_q) begin
          fails++;
          $display("FAIL %s dut%0d count=%0d expected=%0d", it.tag, it.idx,
                   cnt_w[it.idx], it.exp_q);
        end
        checks++;
        if (tc_w[it.idx] !== it.exp_tc) begin
          fails++;
          $display("FAIL R5 dut%0d term_cnt=%0b expected=%0b", it.idx,
                   tc_w[it.idx], it.exp_tc);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < N; i++) model[i] = 0;
    // R1: reset state
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // R7/R6: long enabled run covers rise into window and several full cycles
    repeat (40) step(1'b0, 1'b1);
    // R4: idle stretch, hits end value for dut0 at some point via gaps
    repeat (5) step(1'b0, 1'b0);
    for (int k = 0; k < 60; k++) step(1'b0, (k % 4) != 3);
    // R4: park each counter at its end value then idle
    step(1'b1, 1'b0);
    repeat (5) step(1'b0, 1'b1);      // dut0 at 5
    repeat (3) step(1'b0, 1'b0);
    step(1'b0, 1'b1);                 // R3 wrap for dut0
    // R1: clear while enabled at the end value of dut1 (reaches 11 after 11 steps)
    step(1'b1, 1'b1);
    repeat (11) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    // R5/R3: dut2 reaches 15, tc, then wraps to 3
    repeat (15) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    repeat (20) step(1'b0, 1'b1);
    // pseudo-random tail
    for (int k = 0; k < 80; k++) step((k % 29) == 28, $urandom_range(0, 3) != 0);
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule